// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block pulls a clean vertical sync out of a composite sync stream. The stream carries short line pulses and long frame pulses. The input has already been made active-high. A slow sample tick is derived from the system clock. On each tick, an 8-bit counter works as a leaky integrator: it climbs while sync is active and sinks, never below zero, while sync is idle. Line pulses are short, so the counter drains away between them. A frame pulse lasts much longer and pushes the counter past a programmable threshold, and that marks the start of vertical sync.

Once vertical sync is asserted, the same counter times how long the input stays idle. Vertical sync ends only after the threshold count of consecutive idle ticks. Any return of the input to active restarts that timing. Brief gaps such as serrations or noise therefore cannot end the pulse early. The threshold is a single value shared by both phases. It is chosen to lie between the line pulse width and the frame pulse width, measured in ticks.

Top module: `csync_vsep`

## Requirements
- R1: After a synchronous reset, `vs_o` is low and the block is searching with its counter at zero. A reset asserted while vertical sync is high drives `vs_o` low on the next clock.
- R2: While searching, an active pulse of at most `thr_i` ticks does not raise `vs_o`. Examples are 5 ticks, or exactly `thr_i` ticks.
- R3: While searching, an active pulse of `thr_i`+1 ticks raises `vs_o`, because the count then exceeds `thr_i`.
- R4: While searching, each idle tick lowers the count by one, and the count stops at zero. With `thr_i`=20, a repeated pattern of 10 active and 5 idle ticks raises `vs_o`. A pattern of 10 active and 10 idle ticks never does.
- R5: While `vs_o` is high, `thr_i` consecutive idle ticks lower `vs_o`. Only `thr_i`-1 idle ticks leave it high.
- R6: While `vs_o` is high, an active tick restarts the idle timing from zero. With `thr_i`=20, gaps of 10 idle ticks separated by 2 active ticks keep `vs_o` high.
- R7: The counter saturates at 255 and never wraps. After 300 active ticks with `thr_i`=255, `vs_o` stays low. Lowering `thr_i` to 250 then raises `vs_o` on the next active tick.
- R8: With `thr_i`=0, a single active tick raises `vs_o` and a single idle tick lowers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| csync_i | input | 1 | Composite sync, active-high, asynchronous to clk_i |
| thr_i | input | 8 | Threshold count T, in ticks |
| vs_o | output | 1 | Registered vertical sync, active-high |

## Verification
The checker assumes that the counter moves only on divider ticks and that it sees the input only after the two-flop synchronizer. It also assumes that the threshold is a plain level sampled on each tick. The bench changes the input and the threshold only on falling clock edges. Every pulse and gap it applies lasts a whole number of tick periods, so the synchronized input always spans an exact number of ticks. Results are sampled two cycles after each input edge. At that point every tick of the finished interval has taken effect, and the tick that follows has not yet occurred.

// File: rtl/csync_pkg.sv
package csync_pkg;

  typedef enum logic {
    PH_SEARCH = 1'b0,
    PH_ABSENT = 1'b1
  } vsep_phase_e;

endpackage

// File: rtl/csync_sync.sv
module csync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) pipe_q[s] <= 1'b0;
          else       pipe_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) pipe_q[s] <= 1'b0;
          else       pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/csync_tick.sv
module csync_tick #(
  parameter int CLK_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);

  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)              div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);

endmodule

// File: rtl/csync_core.sv
module csync_core
  import csync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output vsep_phase_e      phase_o,
  output logic             vs_o
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_up;
  logic [CNT_W-1:0] cnt_dn;
  vsep_phase_e      phase_q;
  logic             vs_q;

  // saturating step values
  assign cnt_up = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
  assign cnt_dn = (cnt_q == '0) ? '0 : cnt_q - 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_SEARCH;
      cnt_q   <= '0;
      vs_q    <= 1'b0;
    end else if (tick_i) begin
      unique case (phase_q)
        PH_SEARCH: begin
          if (sync_i) begin
            if (cnt_up > thr_i) begin
              phase_q <= PH_ABSENT;
              cnt_q   <= '0;
              vs_q    <= 1'b1;
            end else begin
              cnt_q <= cnt_up;
            end
          end else begin
            cnt_q <= cnt_dn;
          end
        end
        PH_ABSENT: begin
          if (sync_i) begin
            cnt_q <= '0;
          end else if (cnt_up >= thr_i) begin
            phase_q <= PH_SEARCH;
            cnt_q   <= '0;
            vs_q    <= 1'b0;
          end else begin
            cnt_q <= cnt_up;
          end
        end
        default: begin
          phase_q <= PH_SEARCH;
          cnt_q   <= '0;
          vs_q    <= 1'b0;
        end
      endcase
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;
  assign vs_o    = vs_q;

endmodule

// File: rtl/csync_vsep.sv
module csync_vsep
  import csync_pkg::*;
#(
  parameter int CLK_DIV     = 10,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             csync_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             vs_o
);

  logic             tick_w;
  logic             sync_w;
  logic [CNT_W-1:0] cnt_w;
  vsep_phase_e      phase_w;

  csync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (csync_i),
    .q_o   (sync_w)
  );

  csync_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_o (tick_w)
  );

  csync_core #(.CNT_W(CNT_W)) u_core (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick_w),
    .sync_i  (sync_w),
    .thr_i   (thr_i),
    .cnt_o   (cnt_w),
    .phase_o (phase_w),
    .vs_o    (vs_o)
  );

endmodule

// File: rtl/csync_vsep_chk.sv
module csync_vsep_chk
  import csync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             tick,
  input logic             sin,
  input logic [CNT_W-1:0] cnt,
  input vsep_phase_e      phase,
  input logic             vs_o
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R1: reset forces vs low
  assert_reset_low_R1: assert property (@(posedge clk_i)
    rst_i |=> !vs_o);

  // R3: vertical sync starts only on a tick, from the search phase, while input active
  assert_rise_on_tick_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    tick && phase == PH_SEARCH && !sin |=> !$rose(vs_o));

  assert_rise_clears_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(vs_o) |-> cnt == '0 && phase == PH_ABSENT);

  // R4: search count floors at zero on idle ticks
  assert_floor_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    tick && phase == PH_SEARCH && !sin && cnt == '0 |=> cnt == '0 && !vs_o);

  // R5: vertical sync never ends while input is active
  assert_no_end_active_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    tick && phase == PH_ABSENT && sin |=> vs_o);

  // R6: an active tick during absence timing restarts the count
  assert_absent_restart_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    tick && phase == PH_ABSENT && sin |=> cnt == '0);

  // R7: count at the top stays at the top unless detection cleared it
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    tick && phase == PH_SEARCH && sin && cnt == CMAX |=> cnt == CMAX || vs_o);

  // output moves only after a tick
  assert_vs_on_tick_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick |=> $stable(vs_o));

endmodule

bind csync_vsep csync_vsep_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .tick  (tick_w),
  .sin   (sync_w),
  .cnt   (cnt_w),
  .phase (phase_w),
  .vs_o  (vs_o)
);

// File: tb/tb_csync_vsep.sv
module tb_csync_vsep;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NVEC       = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic       csync;
  logic [7:0] thr;
  logic       vs;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csync_vsep #(.CLK_DIV(DIV), .CNT_W(8), .SYNC_STAGES(2)) dut (
    .clk_i   (clk),
    .rst_i   (rst),
    .csync_i (csync),
    .thr_i   (thr),
    .vs_o    (vs)
  );

  // fields: thr[41:34] pulse[33:18] gap[17:2] exp_after_pulse[1] exp_after_gap[0]
  localparam logic [41:0] VEC [NVEC] = '{
    {8'd20, 16'd5,  16'd10, 1'b0, 1'b0},
    {8'd20, 16'd20, 16'd10, 1'b0, 1'b0},
    {8'd20, 16'd21, 16'd25, 1'b1, 1'b0},
    {8'd20, 16'd30, 16'd19, 1'b1, 1'b1},
    {8'd20, 16'd30, 16'd20, 1'b1, 1'b0},
    {8'd0,  16'd10, 16'd2,  1'b1, 1'b0}
  };
  localparam string TAG_P [NVEC] = '{"R2", "R2", "R3", "R3", "R3", "R8"};
  localparam string TAG_G [NVEC] = '{"R2", "R2", "R5", "R5", "R5", "R8"};

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: vs_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst   = 1'b1;
    csync = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic hold(input logic level, input int ticks);
    csync = level;
    repeat (ticks * DIV) @(negedge clk);
  endtask

  initial begin
    thr = 8'd20;
    do_reset();
    check("R1", vs, 1'b0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      thr   = VEC[i][41:34];
      csync = 1'b1;
      repeat (int'(VEC[i][33:18]) * DIV) @(negedge clk);
      csync = 1'b0;
      repeat (2) @(negedge clk);
      check(TAG_P[i], vs, VEC[i][1]);
      repeat (int'(VEC[i][17:2]) * DIV - 2) @(negedge clk);
      csync = 1'b1;
      repeat (2) @(negedge clk);
      check(TAG_G[i], vs, VEC[i][0]);
      csync = 1'b0;
    end

    // R4: integration, net gain detects
    do_reset();
    thr = 8'd20;
    for (int k = 0; k < 6; k++) begin
      hold(1'b1, 10);
      hold(1'b0, 5);
    end
    check("R4", vs, 1'b1);

    // R4: balanced duty drains to zero, never detects
    do_reset();
    for (int k = 0; k < 6; k++) begin
      hold(1'b1, 10);
      hold(1'b0, 10);
    end
    check("R4", vs, 1'b0);

    // R6: serration gaps do not end vertical sync
    do_reset();
    hold(1'b1, 30);
    for (int k = 0; k < 5; k++) begin
      hold(1'b0, 10);
      hold(1'b1, 2);
    end
    check("R6", vs, 1'b1);
    hold(1'b0, 25);
    check("R6", vs, 1'b0);

    // R7: saturation, no wrap
    do_reset();
    thr = 8'd255;
    hold(1'b1, 300);
    check("R7", vs, 1'b0);
    thr = 8'd250;
    repeat (DIV + 1) @(negedge clk);
    check("R7", vs, 1'b1);
    csync = 1'b0;

    // R1: reset during vertical sync
    do_reset();
    thr = 8'd20;
    hold(1'b1, 25);
    check("R3", vs, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", vs, 1'b0);
    rst   = 1'b0;
    csync = 1'b0;
    hold(1'b1, 5);
    csync = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", vs, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule